// File: doc/BRIEF.md
# Cache line maintenance command sequencer

This block takes a single cache maintenance request and expands it into a stream of per-line register writes to a cache controller. Each request names an operation, a physical and a virtual start address, a byte count and a flag that marks a whole, page-aligned page. From the operation the block picks which controller register receives the writes. For partial requests it widens the range out to whole lines, counts the lines, and then issues one write per line (or a tag/command pair per line) over a valid/ready write port.

A mode input selects between two address formats, both used to maintain a virtually indexed cache that can alias. In packed mode, five virtual page-number bits ride in the low bits of each line address, which would otherwise be unused. In split mode, the physical address goes to a tag register and the virtual address goes to the command register. A one-cycle done pulse marks the end of every request.

Top module: `cmaint_seq`

## Requirements
- R1: Operation codes are 1 invalidate, 2 write back, 3 write back then invalidate, 4 instruction invalidate. Code 4 writes register code 0 (instruction line invalidate). Any other code with bit 0 set writes register code 1 (data line invalidate). All remaining codes write register code 2 (data line flush). Tag writes use register code 3 for operation 4 and register code 4 for every other operation.
- R2: For a request that is not a full page, the line count is ceil((size + paddr mod LINE_BYTES) / LINE_BYTES). For a full page it is ceil(size / LINE_BYTES).
- R3: For a request that is not a full page, the physical and virtual addresses are rounded down to a line boundary before the first write. Full-page addresses are used as given.
- R4: In packed mode (split_mode=0), each command write carries the current physical line address ORed with vaddr[17:13] in bits [4:0].
- R5: In split mode for a request that is not a full page, each line produces a tag write of the physical line address, followed at once by a command write of the virtual line address.
- R6: In split mode for a full-page request, a single tag write of the physical address comes first, followed only by command writes.
- R7: Successive lines advance the addresses written by LINE_BYTES.
- R8: done is high for exactly one cycle. It rises in the cycle after the final write is accepted, when the block is idle again.
- R9: A request of size zero produces no writes and raises done in the cycle after acceptance.
- R10: While wr_valid is high and wr_ready is low, wr_valid, wr_reg and wr_data stay unchanged.
- R11: req_ready is high only when no write is pending. A request is accepted on a cycle where both req_valid and req_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_op | input | 3 | Operation code |
| req_paddr | input | AW | Physical start address |
| req_vaddr | input | AW | Virtual start address |
| req_size | input | SW | Byte count |
| req_full_page | input | 1 | Request covers exactly one aligned page |
| split_mode | input | 1 | 1 = tag/command pairs, 0 = packed virtual bits |
| wr_valid | output | 1 | Register write present |
| wr_ready | input | 1 | Controller accepts the write |
| wr_reg | output | 3 | Target register code |
| wr_data | output | AW | Value written |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 64-byte lines, a page shift of 13 and five packed bits, with a 16-bit size. It sweeps both modes, both full-page settings, all four operations, start offsets at the edges of a line, and sizes of zero, one, exactly one line and a little over one line. This covers partial first lines, ranges that spill into an extra line, empty requests, and packed bits that change with every virtual page. The write port stalls in a fixed rotating pattern, so outputs are observed while they are held under back-pressure.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [2:0] {
    REG_IC_LINE_INV = 3'd0,
    REG_DC_LINE_INV = 3'd1,
    REG_DC_LINE_FLUSH = 3'd2,
    REG_IC_TAG = 3'd3,
    REG_DC_TAG = 3'd4
  } cms_reg_e;

  localparam logic [2:0] OPC_INV = 3'd1;
  localparam logic [2:0] OPC_WB = 3'd2;
  localparam logic [2:0] OPC_WB_INV = 3'd3;
  localparam logic [2:0] OPC_IC_INV = 3'd4;

  function automatic cms_reg_e cmd_target(input logic [2:0] op);
    if (op == OPC_IC_INV) return REG_IC_LINE_INV;
    else if (op[0]) return REG_DC_LINE_INV;
    else return REG_DC_LINE_FLUSH;
  endfunction

  function automatic cms_reg_e tag_target(input logic [2:0] op);
    return (op == OPC_IC_INV) ? REG_IC_TAG : REG_DC_TAG;
  endfunction

endpackage

// File: rtl/cms_decode.sv
module cms_decode
  import cms_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PACK_W = 5,
  localparam int LSH = $clog2(LINE_BYTES),
  localparam int CW = SW + 2
) (
  input  logic [2:0]        op,
  input  logic [AW-1:0]     paddr,
  input  logic [AW-1:0]     vaddr,
  input  logic [SW-1:0]     size,
  input  logic              full_page,
  output cms_reg_e          cmd_reg,
  output cms_reg_e          tag_reg,
  output logic [AW-1:0]     p_start,
  output logic [AW-1:0]     v_start,
  output logic [PACK_W-1:0] pack_bits,
  output logic [CW-1:0]     n_lines,
  output logic              is_empty
);

  localparam logic [AW-1:0] LMASK = AW'(LINE_BYTES - 1);

  logic [CW-1:0] offset;
  logic [CW-1:0] adj_size;

  always_comb begin
    cmd_reg   = cmd_target(op);
    tag_reg   = tag_target(op);
    offset    = full_page ? '0 : CW'(paddr[LSH-1:0]);
    adj_size  = CW'(size) + offset;
    n_lines   = (adj_size + CW'(LINE_BYTES - 1)) >> LSH;
    p_start   = full_page ? paddr : (paddr & ~LMASK);
    v_start   = full_page ? vaddr : (vaddr & ~LMASK);
    pack_bits = vaddr[PAGE_SHIFT +: PACK_W];
    is_empty  = (size == '0);
  end

endmodule

// File: rtl/cms_engine.sv
module cms_engine
  import cms_pkg::*;
#(
  parameter int AW = 32,
  parameter int LINE_BYTES = 64,
  parameter int PACK_W = 5,
  parameter int CW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_empty,
  input  logic              split_in,
  input  logic              full_in,
  input  cms_reg_e          cmd_reg_in,
  input  cms_reg_e          tag_reg_in,
  input  logic [AW-1:0]     p_in,
  input  logic [AW-1:0]     v_in,
  input  logic [PACK_W-1:0] pack_in,
  input  logic [CW-1:0]     lines_in,
  output logic              idle,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [2:0]        wr_reg,
  output logic [AW-1:0]     wr_data,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_TAG, S_CMD} st_e;

  st_e               st;
  logic [CW-1:0]     remain;
  logic [AW-1:0]     pcur;
  logic [AW-1:0]     vcur;
  logic [PACK_W-1:0] pack_q;
  logic              split_q;
  logic              full_q;
  cms_reg_e          cmd_q;
  cms_reg_e          tag_q;

  logic fire;
  logic tag_fire;
  logic cmd_fire;
  logic last_fire;

  assign idle      = (st == S_IDLE);
  assign wr_valid  = (st != S_IDLE);
  assign fire      = wr_valid && wr_ready;
  assign tag_fire  = fire && (st == S_TAG);
  assign cmd_fire  = fire && (st == S_CMD);
  assign last_fire = cmd_fire && (remain == CW'(1));

  always_comb begin
    if (st == S_TAG) begin
      wr_reg  = tag_q;
      wr_data = pcur;
    end else begin
      wr_reg  = cmd_q;
      wr_data = split_q ? vcur : (pcur | AW'(pack_q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      remain  <= '0;
      pcur    <= '0;
      vcur    <= '0;
      pack_q  <= '0;
      split_q <= 1'b0;
      full_q  <= 1'b0;
      cmd_q   <= REG_IC_LINE_INV;
      tag_q   <= REG_IC_TAG;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (start_empty) begin
              done <= 1'b1;
            end else begin
              remain  <= lines_in;
              pcur    <= p_in;
              vcur    <= v_in;
              pack_q  <= pack_in;
              split_q <= split_in;
              full_q  <= full_in;
              cmd_q   <= cmd_reg_in;
              tag_q   <= tag_reg_in;
              st      <= split_in ? S_TAG : S_CMD;
            end
          end
        end
        S_TAG: begin
          if (tag_fire) begin
            if (!full_q) pcur <= pcur + AW'(LINE_BYTES);
            st <= S_CMD;
          end
        end
        S_CMD: begin
          if (cmd_fire) begin
            vcur   <= vcur + AW'(LINE_BYTES);
            if (!split_q) pcur <= pcur + AW'(LINE_BYTES);
            remain <= remain - CW'(1);
            if (last_fire) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else if (split_q && !full_q) begin
              st <= S_TAG;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: held write stays put under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_reg)));

  // R5: an accepted tag write is followed by a command write
  a_r5_tag_then_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    tag_fire |=> (wr_valid && (wr_reg == 3'(cmd_q))));

  // R6: full-page split runs issue no further tag writes after a command
  a_r6_single_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && split_q && full_q && !last_fire) |=> (wr_reg == 3'(cmd_q)));

  // R8: done only when idle, and never two cycles running
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_valid && idle));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: empty request completes without writes
  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_empty && idle) |=> (done && !wr_valid));

endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
  import cms_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PACK_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_paddr,
  input  logic [AW-1:0] req_vaddr,
  input  logic [SW-1:0] req_size,
  input  logic          req_full_page,
  input  logic          split_mode,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [2:0]    wr_reg,
  output logic [AW-1:0] wr_data,
  output logic          done
);

  localparam int CW = SW + 2;

  cms_reg_e          d_cmd;
  cms_reg_e          d_tag;
  logic [AW-1:0]     d_p;
  logic [AW-1:0]     d_v;
  logic [PACK_W-1:0] d_pack;
  logic [CW-1:0]     d_lines;
  logic              d_empty;
  logic              accept;

  assign accept = req_valid && req_ready;

  cms_decode #(
    .AW(AW), .SW(SW), .LINE_BYTES(LINE_BYTES),
    .PAGE_SHIFT(PAGE_SHIFT), .PACK_W(PACK_W)
  ) u_dec (
    .op(req_op), .paddr(req_paddr), .vaddr(req_vaddr), .size(req_size),
    .full_page(req_full_page), .cmd_reg(d_cmd), .tag_reg(d_tag),
    .p_start(d_p), .v_start(d_v), .pack_bits(d_pack),
    .n_lines(d_lines), .is_empty(d_empty)
  );

  cms_engine #(
    .AW(AW), .LINE_BYTES(LINE_BYTES), .PACK_W(PACK_W), .CW(CW)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_empty(d_empty),
    .split_in(split_mode), .full_in(req_full_page),
    .cmd_reg_in(d_cmd), .tag_reg_in(d_tag), .p_in(d_p), .v_in(d_v),
    .pack_in(d_pack), .lines_in(d_lines), .idle(req_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_reg(wr_reg),
    .wr_data(wr_data), .done(done)
  );

  // R11: no pending write while a request may be taken
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wr_valid);

endmodule

// File: tb/cmaint_seq_tb.sv
module cmaint_seq_tb;

  localparam int AW = 32;
  localparam int SW = 16;
  localparam int LB = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = 3'd1;
  logic [AW-1:0] req_paddr = '0;
  logic [AW-1:0] req_vaddr = '0;
  logic [SW-1:0] req_size = '0;
  logic          req_full_page = 1'b0;
  logic          split_mode = 1'b0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [2:0]    wr_reg;
  logic [AW-1:0] wr_data;
  logic          done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [2:0]    exp_reg [0:15];
  logic [AW-1:0] exp_dat [0:15];

  always #10 clk = ~clk;

  cmaint_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_paddr(req_paddr), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_full_page(req_full_page),
    .split_mode(split_mode), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_reg(wr_reg), .wr_data(wr_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] op, input logic [AW-1:0] pa,
                         input logic [AW-1:0] va, input int size,
                         input bit full, input bit split);
    int n, cnt, idx, off, waitc;
    logic [AW-1:0] p, v;
    logic [4:0] st;
    logic [2:0] tcmd, ttag;
    tcmd = (op == 3'd4) ? 3'd0 : (op[0] ? 3'd1 : 3'd2);
    ttag = (op == 3'd4) ? 3'd3 : 3'd4;
    off = full ? 0 : int'(pa % LB);
    n = (size == 0) ? 0 : (size + off + LB - 1) / LB;
    p = full ? pa : pa - (pa % LB);
    v = full ? va : va - (va % LB);
    st = va[17:13];
    cnt = 0;
    if (n > 0 && split && full) begin
      exp_reg[cnt] = ttag; exp_dat[cnt] = p; cnt++;
    end
    for (int i = 0; i < n; i++) begin
      if (split && !full) begin
        exp_reg[cnt] = ttag; exp_dat[cnt] = p + AW'(LB * i); cnt++;
      end
      exp_reg[cnt] = tcmd;
      exp_dat[cnt] = split ? v + AW'(LB * i) : ((p + AW'(LB * i)) | AW'(st));
      cnt++;
    end
    // R11: idle block offers ready
    check(req_ready === 1'b1 && wr_valid === 1'b0, "R11", "ready when idle",
          AW'({req_ready, wr_valid}), AW'(2));
    req_op = op; req_paddr = pa; req_vaddr = va; req_size = SW'(size);
    req_full_page = full; split_mode = split; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (cnt == 0) begin
      // R9: empty request
      check(done === 1'b1 && wr_valid === 1'b0, "R9", "empty done",
            AW'({done, wr_valid}), AW'(2));
      @(negedge clk);
      check(done === 1'b0, "R8", "done single cycle", AW'(done), AW'(0));
      return;
    end
    check(req_ready === 1'b0, "R11", "busy not ready", AW'(req_ready), AW'(0));
    idx = 0;
    waitc = 0;
    while (idx < cnt && waitc < 1000) begin
      cyc++;
      wr_ready = (cyc % 4 != 2);
      if (done === 1'b1)
        check(1'b0, "R8", "early done", AW'(idx), AW'(cnt));
      if (wr_valid && wr_ready) begin
        // R1 R3 R4 R5 R6 R7: register code and data of each write
        check(wr_reg === exp_reg[idx] && wr_data === exp_dat[idx],
              split ? (full ? "R6" : "R5") : "R4", "write reg/data",
              {wr_reg, wr_data[AW-4:0]}, {exp_reg[idx], exp_dat[idx][AW-4:0]});
        if (wr_data !== exp_dat[idx])
          $display("  detail: R1/R3/R7 op=%0d full=%0d split=%0d idx=%0d data %h exp %h",
                   op, full, split, idx, wr_data, exp_dat[idx]);
        idx++;
      end
      waitc++;
      @(negedge clk);
    end
    if (idx < cnt) check(1'b0, "R2", "missing writes", AW'(idx), AW'(cnt));
    wr_ready = 1'b0;
    // R2 R8: exact count, done one cycle after last write
    check(done === 1'b1 && wr_valid === 1'b0, "R8", "done after last",
          AW'({done, wr_valid}), AW'(2));
    @(negedge clk);
    check(done === 1'b0 && wr_valid === 1'b0, "R2", "no extra write",
          AW'({done, wr_valid}), AW'(0));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int offs[4];
    int sizes[6];
    int k;
    offs[0] = 0; offs[1] = 1; offs[2] = 31; offs[3] = 63;
    sizes[0] = 0; sizes[1] = 1; sizes[2] = 63; sizes[3] = 64;
    sizes[4] = 65; sizes[5] = 200;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && wr_valid === 1'b0 && done === 1'b0,
          "R11", "reset state", AW'({req_ready, wr_valid, done}), AW'(4));
    rst_n = 1'b1;
    @(negedge clk);
    k = 0;
    for (int sm = 0; sm < 2; sm++)
      for (int fp = 0; fp < 2; fp++)
        for (int op = 1; op <= 4; op++)
          for (int oi = 0; oi < 4; oi++)
            for (int si = 0; si < 6; si++) begin
              k++;
              run_req(3'(op), 32'h8004_0000 + AW'(k * 256) + AW'(offs[oi]),
                      AW'(k * 8192 * 3) + AW'(offs[oi] + 128),
                      sizes[si], fp[0], sm[0]);
            end
    // R10: long stall holds the first write
    req_op = 3'd3; req_paddr = 32'h1000_0040; req_vaddr = 32'h0001_E040;
    req_size = 16'd64; req_full_page = 1'b0; split_mode = 1'b0;
    req_valid = 1'b1; wr_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(wr_valid === 1'b1 && wr_reg === 3'd1 && wr_data === 32'h1000_004F,
          "R10", "held under stall", wr_data, 32'h1000_004F);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    check(done === 1'b1, "R10", "completes after release", AW'(done), AW'(1));
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule